// File: doc/BRIEF.md
# Interrupt-Enable and Control Register Unit

This block holds the control and status registers of a small 32-bit processor core. A register read or write instruction selects one of 32 slots with a 5-bit index. Each slot has its own access rule. Some slots can be read and written. Some can only be read: the free-running cycle count and a fixed configuration word. Some can only be written: two cache-control slots and the breakpoint and watchpoint address slots. Any access that breaks a slot's rule gets an illegal-access response, and so does any index that names no slot. The interrupt-mask, interrupt-pending and two debug-channel data registers are kept outside the block. The block reads them from input ports and writes them through strobes.

The three-bit interrupt-enable word consists of a global enable (bit 0), a copy saved on exception entry (bit 1) and a copy saved on breakpoint entry (bit 2). The pipeline signals four events to the block: exception entry, breakpoint entry, exception return and breakpoint return. On these events the global bit is saved and cleared, or restored from the matching saved copy. The block also decodes trap instructions from their 5-bit immediate. A code of 7 is a system call and a code of 2 is a breakpoint. For either one, the block reports the address of the trap instruction itself as the return address. Any other code is reported as bad.

Every response is produced by a small response state machine with four states. RSP_IDLE means no response this cycle. RSP_RDATA means a legal read whose data is on the response bus. RSP_WACK means a legal write has been accepted. RSP_FAULT means an illegal access. Each cycle the machine moves from whatever state it is in to the state selected by the request sampled on that edge. With no request it goes to RSP_IDLE. A legal read goes to RSP_RDATA and a legal write to RSP_WACK. Any illegal read or write goes to RSP_FAULT. If read and write are requested in the same cycle, the read is served and the write is dropped.

Top module: `csr_ctl_unit`

Slot indices: 0 interrupt enable, 1 mask (external), 2 pending (external), 3 and 4 cache control, 5 cycle count, 6 configuration, 7 exception base, 8 debug control, 9 debug base, 14 and 15 debug-channel transmit and receive (external), 16 to 19 breakpoints 0 to 3, 24 to 27 watchpoints 0 to 3.

## Requirements
- R1: After reset, ie_state is 0, dbgctl_q is 0, rsp_valid is 0 and reading slot 8 returns 0.
- R2: A legal read or write gives rsp_valid=1 and rsp_illegal=0 one cycle after the request. A read returns the slot's value, and slots 7, 8 and 9 return what was last written to them. A read of slot 0 returns ie_state in bits 2:0 with zeros above.
- R3: On exception entry, bit 1 of ie_state takes the old bit 0 and bit 0 clears. On breakpoint entry, bit 2 takes the old bit 0 and bit 0 clears.
- R4: On exception return, bit 0 takes bit 1. On breakpoint return, bit 0 takes bit 2. The saved bits stay unchanged in both cases.
- R5: A write to slot 5 or slot 6 is illegal and changes nothing. Slot 6 always reads as the CFG_WORD parameter.
- R6: The cycle count rises by one every clock and wraps at 2^32. Two reads of slot 5 whose requests are N cycles apart differ by N.
- R7: A read of slot 3, 4, 16 to 19 or 24 to 27 is illegal and returns 0. A write to slot 3 or 4 is legal.
- R8: A breakpoint or watchpoint write whose number (index bits 1:0) is not below NUM_BP or NUM_WP is illegal and leaves bp_addr and wp_addr unchanged. A legal write shows up on the matching 32-bit field of bp_addr or wp_addr one cycle later.
- R9: An index that names no slot is illegal for both read and write.
- R10: A legal write to slot 0, 1 or 2 pulses irq_recheck one cycle later. A write to slot 1, 2, 14 or 15 pulses the matching strobe together with ext_wdata, and a read of one of these slots returns the matching input port.
- R11: A trap request with code 7 or code 2 gives trap_take=1 one cycle later, with trap_is_brk set only for code 2 and trap_epc equal to the request's PC. Any other code gives trap_bad=1 and trap_take=0.
- R12: Entry and return events win over a write to slot 0 in the same cycle. The priority order is exception entry, then breakpoint entry, then exception return, then breakpoint return, then the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Register read request |
| req_wr | input | 1 | Register write request |
| req_idx | input | 5 | Slot index |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Response is an illegal access |
| rsp_rdata | output | 32 | Read data (0 unless legal read) |
| exc_enter | input | 1 | Exception entry event |
| brk_enter | input | 1 | Breakpoint entry event |
| exc_return | input | 1 | Exception return event |
| brk_return | input | 1 | Breakpoint return event |
| ie_state | output | 3 | {break-saved, exception-saved, global} enable |
| irq_recheck | output | 1 | Interrupt state may have changed |
| ext_mask_q | input | 32 | External mask register value |
| ext_pend_q | input | 32 | External pending register value |
| dbg_tx_q | input | 32 | Debug transmit register value |
| dbg_rx_q | input | 32 | Debug receive register value |
| mask_we | output | 1 | Mask write strobe |
| pend_we | output | 1 | Pending write strobe |
| dbg_tx_we | output | 1 | Debug transmit write strobe |
| dbg_rx_we | output | 1 | Debug receive write strobe |
| ext_wdata | output | 32 | Data for the external strobes |
| eba_q | output | 32 | Exception base address |
| deba_q | output | 32 | Debug base address |
| dbgctl_q | output | 32 | Debug control register |
| bp_addr | output | NUM_BP*32 | Breakpoint addresses, unit i at bits 32i+31:32i |
| wp_addr | output | NUM_WP*32 | Watchpoint addresses, unit i at bits 32i+31:32i |
| trap_req | input | 1 | Trap instruction present |
| trap_code | input | 5 | Trap 5-bit immediate |
| trap_pc | input | 32 | Address of the trap instruction |
| trap_take | output | 1 | System call or breakpoint trap raised |
| trap_is_brk | output | 1 | Raised trap is a breakpoint |
| trap_bad | output | 1 | Trap code is not defined |
| trap_epc | output | 32 | Return address of the trap |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. That covers the response triple, the interrupt-enable bits, the external strobes with ext_wdata, irq_recheck, the address outputs and the trap outputs. The driver applies each request at a falling edge and pushes the expected response into a queue at that same moment. The monitor compares the response at the next falling edge, so it always samples exactly one rising edge after the request. Non-response results are sampled at the falling edge that ends the stimulus cycle. For the cycle count, the expected value is the difference from the previous count read, equal to the number of cycles between the two requests.

// File: rtl/csr_ctl_pkg.sv
package csr_ctl_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 5;

    localparam logic [IDX_W-1:0] IDX_IE    = 5'd0;
    localparam logic [IDX_W-1:0] IDX_MASK  = 5'd1;
    localparam logic [IDX_W-1:0] IDX_PEND  = 5'd2;
    localparam logic [IDX_W-1:0] IDX_ICTL  = 5'd3;
    localparam logic [IDX_W-1:0] IDX_DCTL  = 5'd4;
    localparam logic [IDX_W-1:0] IDX_CYC   = 5'd5;
    localparam logic [IDX_W-1:0] IDX_CFG   = 5'd6;
    localparam logic [IDX_W-1:0] IDX_EBASE = 5'd7;
    localparam logic [IDX_W-1:0] IDX_DCTRL = 5'd8;
    localparam logic [IDX_W-1:0] IDX_DBASE = 5'd9;
    localparam logic [IDX_W-1:0] IDX_DTX   = 5'd14;
    localparam logic [IDX_W-1:0] IDX_DRX   = 5'd15;

    localparam logic [IDX_W-1:0] TRAP_SYSCALL = 5'd7;
    localparam logic [IDX_W-1:0] TRAP_BREAK   = 5'd2;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_RDATA = 2'd1,
        RSP_WACK  = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_state_e;

    typedef struct packed {
        logic can_rd;
        logic can_wr;
        logic is_bp;
        logic is_wp;
    } slot_class_t;

    function automatic slot_class_t classify(input logic [IDX_W-1:0] idx);
        slot_class_t c;
        c = '0;
        case (idx)
            IDX_IE, IDX_MASK, IDX_PEND, IDX_EBASE,
            IDX_DCTRL, IDX_DBASE, IDX_DTX, IDX_DRX: begin
                c.can_rd = 1'b1;
                c.can_wr = 1'b1;
            end
            IDX_ICTL, IDX_DCTL: c.can_wr = 1'b1;
            IDX_CYC, IDX_CFG:   c.can_rd = 1'b1;
            5'd16, 5'd17, 5'd18, 5'd19: begin
                c.can_wr = 1'b1;
                c.is_bp  = 1'b1;
            end
            5'd24, 5'd25, 5'd26, 5'd27: begin
                c.can_wr = 1'b1;
                c.is_wp  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/csr_ie_reg.sv
module csr_ie_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       exc_enter,
    input  logic       brk_enter,
    input  logic       exc_return,
    input  logic       brk_return,
    input  logic       wr_en,
    input  logic [2:0] wr_bits,
    output logic [2:0] ie_q
);
    // bit 0 global, bit 1 exception-saved, bit 2 break-saved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 3'b000;
        end else if (exc_enter) begin
            ie_q <= {ie_q[2], ie_q[0], 1'b0};
        end else if (brk_enter) begin
            ie_q <= {ie_q[0], ie_q[1], 1'b0};
        end else if (exc_return) begin
            ie_q[0] <= ie_q[1];
        end else if (brk_return) begin
            ie_q[0] <= ie_q[2];
        end else if (wr_en) begin
            ie_q <= wr_bits;
        end
    end
endmodule

// File: rtl/csr_cycle_ctr.sv
module csr_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/csr_addr_bank.sv
module csr_addr_bank #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [1:0]     sel,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                    slot_q <= '0;
            else if (we && sel == 2'(i))   slot_q <= wdata;
        end
        assign q[i*W +: W] = slot_q;
    end
endmodule

// File: rtl/csr_ctl_unit.sv
module csr_ctl_unit
    import csr_ctl_pkg::*;
#(
    parameter int          NUM_BP   = 2,
    parameter int          NUM_WP   = 3,
    parameter logic [31:0] CFG_WORD = 32'h00A5_0C31
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_rd,
    input  logic                     req_wr,
    input  logic [4:0]               req_idx,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic                     rsp_illegal,
    output logic [31:0]              rsp_rdata,
    input  logic                     exc_enter,
    input  logic                     brk_enter,
    input  logic                     exc_return,
    input  logic                     brk_return,
    output logic [2:0]               ie_state,
    output logic                     irq_recheck,
    input  logic [31:0]              ext_mask_q,
    input  logic [31:0]              ext_pend_q,
    input  logic [31:0]              dbg_tx_q,
    input  logic [31:0]              dbg_rx_q,
    output logic                     mask_we,
    output logic                     pend_we,
    output logic                     dbg_tx_we,
    output logic                     dbg_rx_we,
    output logic [31:0]              ext_wdata,
    output logic [31:0]              eba_q,
    output logic [31:0]              deba_q,
    output logic [31:0]              dbgctl_q,
    output logic [NUM_BP*32-1:0]     bp_addr,
    output logic [NUM_WP*32-1:0]     wp_addr,
    input  logic                     trap_req,
    input  logic [4:0]               trap_code,
    input  logic [31:0]              trap_pc,
    output logic                     trap_take,
    output logic                     trap_is_brk,
    output logic                     trap_bad,
    output logic [31:0]              trap_epc
);
    localparam int DW = DATA_W;

    rsp_state_e  state_q, state_d;
    slot_class_t cls;
    logic [1:0]  unit;
    logic        unit_ok;
    logic        rd_ok, wr_act, wr_ok;
    logic [DW-1:0] rd_mux, cyc;
    logic [DW-1:0] rdata_q;
    logic [2:0]  ie_q;

    // ---------------- decode ----------------
    always_comb begin
        cls     = classify(req_idx);
        unit    = req_idx[1:0];
        unit_ok = 1'b1;
        if (cls.is_bp && int'(unit) >= NUM_BP) unit_ok = 1'b0;
        if (cls.is_wp && int'(unit) >= NUM_WP) unit_ok = 1'b0;
        rd_ok  = req_rd && cls.can_rd;
        wr_act = req_wr && !req_rd;
        wr_ok  = wr_act && cls.can_wr && unit_ok;
    end

    // ---------------- response state machine ----------------
    always_comb begin
        if (req_rd)      state_d = rd_ok ? RSP_RDATA : RSP_FAULT;
        else if (req_wr) state_d = wr_ok ? RSP_WACK  : RSP_FAULT;
        else             state_d = RSP_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid   = 1'b0;
                rsp_illegal = 1'b0;
                rsp_rdata   = '0;
            end
            RSP_RDATA: begin
                rsp_valid   = 1'b1;
                rsp_illegal = 1'b0;
                rsp_rdata   = rdata_q;
            end
            RSP_WACK: begin
                rsp_valid   = 1'b1;
                rsp_illegal = 1'b0;
                rsp_rdata   = '0;
            end
            RSP_FAULT: begin
                rsp_valid   = 1'b1;
                rsp_illegal = 1'b1;
                rsp_rdata   = '0;
            end
            default: begin
                rsp_valid   = 1'b0;
                rsp_illegal = 1'b0;
                rsp_rdata   = '0;
            end
        endcase
    end

    // ---------------- read path ----------------
    always_comb begin
        case (req_idx)
            IDX_IE:    rd_mux = {{(DW-3){1'b0}}, ie_q};
            IDX_MASK:  rd_mux = ext_mask_q;
            IDX_PEND:  rd_mux = ext_pend_q;
            IDX_CYC:   rd_mux = cyc;
            IDX_CFG:   rd_mux = CFG_WORD;
            IDX_EBASE: rd_mux = eba_q;
            IDX_DCTRL: rd_mux = dbgctl_q;
            IDX_DBASE: rd_mux = deba_q;
            IDX_DTX:   rd_mux = dbg_tx_q;
            IDX_DRX:   rd_mux = dbg_rx_q;
            default:   rd_mux = '0;
        endcase
    end

    // ---------------- local registers and strobes ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q     <= '0;
            eba_q       <= '0;
            deba_q      <= '0;
            dbgctl_q    <= '0;
            mask_we     <= 1'b0;
            pend_we     <= 1'b0;
            dbg_tx_we   <= 1'b0;
            dbg_rx_we   <= 1'b0;
            ext_wdata   <= '0;
            irq_recheck <= 1'b0;
        end else begin
            rdata_q     <= rd_ok ? rd_mux : '0;
            if (wr_ok && req_idx == IDX_EBASE) eba_q    <= req_wdata;
            if (wr_ok && req_idx == IDX_DBASE) deba_q   <= req_wdata;
            if (wr_ok && req_idx == IDX_DCTRL) dbgctl_q <= req_wdata;
            mask_we     <= wr_ok && req_idx == IDX_MASK;
            pend_we     <= wr_ok && req_idx == IDX_PEND;
            dbg_tx_we   <= wr_ok && req_idx == IDX_DTX;
            dbg_rx_we   <= wr_ok && req_idx == IDX_DRX;
            if (wr_ok) ext_wdata <= req_wdata;
            irq_recheck <= wr_ok && (req_idx == IDX_IE || req_idx == IDX_MASK ||
                                     req_idx == IDX_PEND);
        end
    end

    // ---------------- trap decode ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_take   <= 1'b0;
            trap_is_brk <= 1'b0;
            trap_bad    <= 1'b0;
            trap_epc    <= '0;
        end else begin
            trap_take   <= trap_req && (trap_code == TRAP_SYSCALL || trap_code == TRAP_BREAK);
            trap_is_brk <= trap_req && trap_code == TRAP_BREAK;
            trap_bad    <= trap_req && trap_code != TRAP_SYSCALL && trap_code != TRAP_BREAK;
            if (trap_req) trap_epc <= trap_pc;
        end
    end

    // ---------------- sub-blocks ----------------
    csr_ie_reg u_ie (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .brk_enter  (brk_enter),
        .exc_return (exc_return),
        .brk_return (brk_return),
        .wr_en      (wr_ok && req_idx == IDX_IE),
        .wr_bits    (req_wdata[2:0]),
        .ie_q       (ie_q)
    );
    assign ie_state = ie_q;

    csr_cycle_ctr #(.W(DW)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc)
    );

    csr_addr_bank #(.N(NUM_BP), .W(DW)) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && cls.is_bp),
        .sel   (unit),
        .wdata (req_wdata),
        .q     (bp_addr)
    );

    csr_addr_bank #(.N(NUM_WP), .W(DW)) u_wp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && cls.is_wp),
        .sel   (unit),
        .wdata (req_wdata),
        .q     (wp_addr)
    );
endmodule

// File: rtl/csr_ctl_checker.sv
module csr_ctl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_rd,
    input logic        req_wr,
    input logic [4:0]  req_idx,
    input logic        exc_enter,
    input logic        brk_enter,
    input logic        exc_return,
    input logic        brk_return,
    input logic [2:0]  ie_state,
    input logic        rsp_valid,
    input logic        rsp_illegal,
    input logic [31:0] rsp_rdata,
    input logic        irq_recheck,
    input logic        trap_req,
    input logic [4:0]  trap_code,
    input logic [31:0] trap_pc,
    input logic        trap_take,
    input logic        trap_is_brk,
    input logic [31:0] trap_epc
);
    logic wo_slot;
    assign wo_slot = req_idx == 5'd3 || req_idx == 5'd4 ||
                     (req_idx >= 5'd16 && req_idx <= 5'd19) ||
                     (req_idx >= 5'd24 && req_idx <= 5'd27);

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_rd && !req_wr) |=> !rsp_valid);

    assert_exc_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (ie_state[0] == 1'b0 && ie_state[1] == $past(ie_state[0])));

    assert_brk_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_enter && !exc_enter) |=> (ie_state[0] == 1'b0 && ie_state[2] == $past(ie_state[0])));

    assert_exc_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter && !brk_enter) |=>
            (ie_state[0] == $past(ie_state[1]) && ie_state[2:1] == $past(ie_state[2:1])));

    assert_ro_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !req_rd && (req_idx == 5'd5 || req_idx == 5'd6)) |=> (rsp_valid && rsp_illegal));

    assert_wo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && wo_slot) |=> (rsp_illegal && rsp_rdata == 32'd0));

    assert_recheck_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !req_rd && req_idx <= 5'd2) |=> irq_recheck);

    assert_syscall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_code == 5'd7) |=> (trap_take && !trap_is_brk && trap_epc == $past(trap_pc)));
endmodule

bind csr_ctl_unit csr_ctl_checker u_csr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_rd      (req_rd),
    .req_wr      (req_wr),
    .req_idx     (req_idx),
    .exc_enter   (exc_enter),
    .brk_enter   (brk_enter),
    .exc_return  (exc_return),
    .brk_return  (brk_return),
    .ie_state    (ie_state),
    .rsp_valid   (rsp_valid),
    .rsp_illegal (rsp_illegal),
    .rsp_rdata   (rsp_rdata),
    .irq_recheck (irq_recheck),
    .trap_req    (trap_req),
    .trap_code   (trap_code),
    .trap_pc     (trap_pc),
    .trap_take   (trap_take),
    .trap_is_brk (trap_is_brk),
    .trap_epc    (trap_epc)
);

// File: tb/test_csr_ctl_unit.sv
`timescale 1ns/1ps
module test_csr_ctl_unit;
    localparam logic [31:0] CFGW = 32'h00A5_0C31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_rd = 0, req_wr = 0;
    logic [4:0]  req_idx = 0;
    logic [31:0] req_wdata = 0;
    logic        rsp_valid, rsp_illegal;
    logic [31:0] rsp_rdata;
    logic        exc_enter = 0, brk_enter = 0, exc_return = 0, brk_return = 0;
    logic [2:0]  ie_state;
    logic        irq_recheck;
    logic [31:0] ext_mask_q = 32'hCAFE_0001, ext_pend_q = 32'h0000_0F0F;
    logic [31:0] dbg_tx_q = 32'h1111_2222, dbg_rx_q = 32'h3333_4444;
    logic        mask_we, pend_we, dbg_tx_we, dbg_rx_we;
    logic [31:0] ext_wdata, eba_q, deba_q, dbgctl_q;
    logic [63:0] bp_addr;
    logic [95:0] wp_addr;
    logic        trap_req = 0;
    logic [4:0]  trap_code = 0;
    logic [31:0] trap_pc = 0;
    logic        trap_take, trap_is_brk, trap_bad;
    logic [31:0] trap_epc;

    csr_ctl_unit i_csr_ctl_unit (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_idx(req_idx),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
        .rsp_rdata(rsp_rdata), .exc_enter(exc_enter), .brk_enter(brk_enter),
        .exc_return(exc_return), .brk_return(brk_return), .ie_state(ie_state),
        .irq_recheck(irq_recheck), .ext_mask_q(ext_mask_q), .ext_pend_q(ext_pend_q),
        .dbg_tx_q(dbg_tx_q), .dbg_rx_q(dbg_rx_q), .mask_we(mask_we), .pend_we(pend_we),
        .dbg_tx_we(dbg_tx_we), .dbg_rx_we(dbg_rx_we), .ext_wdata(ext_wdata),
        .eba_q(eba_q), .deba_q(deba_q), .dbgctl_q(dbgctl_q), .bp_addr(bp_addr),
        .wp_addr(wp_addr), .trap_req(trap_req), .trap_code(trap_code), .trap_pc(trap_pc),
        .trap_take(trap_take), .trap_is_brk(trap_is_brk), .trap_bad(trap_bad),
        .trap_epc(trap_epc)
    );

    typedef struct packed {
        logic        illegal;
        logic        chk;
        logic [31:0] data;
        logic [1:0]  cc_mode;   // 0 plain, 1 set base, 2 compare to base+delta
        logic [31:0] cc_delta;
        logic [31:0] tag;
    } item_t;

    item_t sb[$];
    int total = 0, bad = 0;
    bit done = 0;
    logic [31:0] cc_base = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected response when one appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                item_t it;
                logic [31:0] exp_d;
                it = sb.pop_front();
                check({string'(it.tag), " illegal"}, {31'd0, rsp_illegal}, {31'd0, it.illegal});
                exp_d = it.data;
                if (it.cc_mode == 2'd2) exp_d = cc_base + it.cc_delta;
                if (it.chk || it.cc_mode == 2'd2) check({string'(it.tag), " data"}, rsp_rdata, exp_d);
                if (it.cc_mode != 2'd0) cc_base = rsp_rdata;
            end
        end
    end

    task automatic push(input logic ill, input logic chk, input logic [31:0] d,
                        input logic [1:0] m, input logic [31:0] dl, input logic [31:0] tag);
        item_t it;
        it.illegal = ill; it.chk = chk; it.data = d; it.cc_mode = m; it.cc_delta = dl; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [4:0] idx, input logic ill, input logic chk,
                      input logic [31:0] d, input logic [31:0] tag);
        req_rd = 1; req_idx = idx;
        push(ill, chk, d, 2'd0, 0, tag);
        @(negedge clk);
        req_rd = 0;
    endtask

    task automatic rd_cc(input logic [1:0] m, input logic [31:0] dl);
        req_rd = 1; req_idx = 5'd5;
        push(1'b0, 1'b0, 0, m, dl, "R6");
        @(negedge clk);
        req_rd = 0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] d, input logic ill,
                      input logic [31:0] tag);
        req_wr = 1; req_idx = idx; req_wdata = d;
        push(ill, 1'b0, 0, 2'd0, 0, tag);
        @(negedge clk);
        req_wr = 0;
    endtask

    task automatic ev(input logic [3:0] e);
        {brk_return, exc_return, brk_enter, exc_enter} = e;
        @(negedge clk);
        {brk_return, exc_return, brk_enter, exc_enter} = 4'b0;
    endtask

    task automatic trap(input logic [4:0] code, input logic [31:0] pc);
        trap_req = 1; trap_code = code; trap_pc = pc;
        @(negedge clk);
        trap_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R1 ie_state", {29'd0, ie_state}, 0);
        check("R1 dbgctl", dbgctl_q, 0);
        rd(5'd8, 0, 1, 32'd0, "R1");

        // R2 plain registers
        wr(5'd7, 32'h1234_5600, 0, "R2");
        wr(5'd9, 32'h00AB_CD00, 0, "R2");
        wr(5'd8, 32'h0000_0005, 0, "R2");
        rd(5'd7, 0, 1, 32'h1234_5600, "R2");
        rd(5'd9, 0, 1, 32'h00AB_CD00, "R2");
        rd(5'd8, 0, 1, 32'h0000_0005, "R2");
        check("R2 eba_q", eba_q, 32'h1234_5600);

        // R10 interrupt-related writes, external reads
        wr(5'd0, 32'hFFFF_FFF9, 0, "R10");
        check("R10 recheck ie", {31'd0, irq_recheck}, 1);
        rd(5'd0, 0, 1, 32'h0000_0001, "R2");
        check("R10 recheck idle", {31'd0, irq_recheck}, 0);
        wr(5'd1, 32'h0000_00F0, 0, "R10");
        check("R10 mask_we", {31'd0, mask_we}, 1);
        check("R10 ext_wdata", ext_wdata, 32'h0000_00F0);
        check("R10 recheck mask", {31'd0, irq_recheck}, 1);
        wr(5'd14, 32'h0000_0041, 0, "R10");
        check("R10 dbg_tx_we", {31'd0, dbg_tx_we}, 1);
        check("R10 no recheck tx", {31'd0, irq_recheck}, 0);
        rd(5'd1, 0, 1, 32'hCAFE_0001, "R10");
        rd(5'd15, 0, 1, 32'h3333_4444, "R10");

        // R3 / R4 enable transitions (ie now 001)
        ev(4'b0001); check("R3 exc entry", {29'd0, ie_state}, 3'b010);
        ev(4'b0100); check("R4 exc return", {29'd0, ie_state}, 3'b011);
        ev(4'b0010); check("R3 brk entry", {29'd0, ie_state}, 3'b110);
        ev(4'b1000); check("R4 brk return", {29'd0, ie_state}, 3'b111);
        wr(5'd0, 32'd0, 0, "R2");
        ev(4'b0001); check("R3 exc entry zero", {29'd0, ie_state}, 3'b000);
        wr(5'd0, 32'd2, 0, "R2");
        ev(4'b0100); check("R4 exc return from saved", {29'd0, ie_state}, 3'b011);
        ev(4'b1000); check("R4 brk return zero", {29'd0, ie_state}, 3'b010);

        // R12 event beats same-cycle IE write
        exc_enter = 1;
        wr(5'd0, 32'd7, 0, "R12");
        exc_enter = 0;
        check("R12 priority", {29'd0, ie_state}, 3'b000);

        // R5 read-only slots
        wr(5'd5, 32'h5555_5555, 1, "R5");
        wr(5'd6, 32'h5555_5555, 1, "R5");
        rd(5'd6, 0, 1, CFGW, "R5");

        // R6 cycle count
        rd_cc(2'd1, 0);
        repeat (10) @(negedge clk);
        rd_cc(2'd2, 32'd11);
        rd_cc(2'd2, 32'd1);

        // R7 write-only slots
        rd(5'd3, 1, 1, 0, "R7");
        rd(5'd4, 1, 1, 0, "R7");
        rd(5'd16, 1, 1, 0, "R7");
        rd(5'd26, 1, 1, 0, "R7");
        wr(5'd3, 32'd1, 0, "R7");

        // R8 breakpoint / watchpoint units (2 and 3 implemented)
        wr(5'd17, 32'hAAAA_0004, 0, "R8");
        check("R8 bp1", bp_addr[63:32], 32'hAAAA_0004);
        wr(5'd18, 32'hBBBB_0008, 1, "R8");
        check("R8 bp unchanged", bp_addr[63:32], 32'hAAAA_0004);
        check("R8 bp0 unchanged", bp_addr[31:0], 32'd0);
        wr(5'd26, 32'hCCCC_0010, 0, "R8");
        check("R8 wp2", wp_addr[95:64], 32'hCCCC_0010);
        wr(5'd27, 32'hDDDD_0020, 1, "R8");
        check("R8 wp unchanged", wp_addr, {32'hCCCC_0010, 64'd0});

        // R9 unmapped indices
        rd(5'd10, 1, 1, 0, "R9");
        wr(5'd31, 32'd9, 1, "R9");

        // R11 traps
        trap(5'd7, 32'h0000_0100);
        check("R11 syscall take", {31'd0, trap_take}, 1);
        check("R11 syscall brk", {31'd0, trap_is_brk}, 0);
        check("R11 syscall epc", trap_epc, 32'h0000_0100);
        trap(5'd2, 32'h0000_0204);
        check("R11 break take", {31'd0, trap_take}, 1);
        check("R11 break brk", {31'd0, trap_is_brk}, 1);
        check("R11 break epc", trap_epc, 32'h0000_0204);
        trap(5'd5, 32'h0000_0300);
        check("R11 bad take", {31'd0, trap_take}, 0);
        check("R11 bad flag", {31'd0, trap_bad}, 1);

        repeat (2) @(negedge clk);
        check("R2 all responses seen", sb.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule